// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block times the read/write strobe of one IDE channel that carries a master and a slave drive. A 16-bit channel timing word holds a flag nibble for each drive, a shared strobe (sample) field, a shared recovery field, a slave-independence bit and a channel enable. An 8-bit side word holds separate sample and recovery fields for the slave of each of two channels. The build-time parameter `CHANNEL_ID` picks which half of the side word this instance reads.

On a cycle request the block takes the selected drive's settings and raises the strobe for the decoded number of clocks. It then holds a recovery gap before it is ready for the next request. When the drive's IORDY option is set, the strobe is stretched while the IORDY input is low. The timing is captured when the request is accepted, so changes to the configuration during a cycle do not affect it.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: After reset `strobe` and `cyc_done` are low, and `ready` is high whenever the channel enable (`chan_cfg[15]`) is set.
- R2: With fast timing in effect, the strobe stays high for 5 minus the sample field `chan_cfg[13:12]` clocks (5, 4, 3 or 2).
- R3: With fast timing in effect, the recovery gap lasts 4 minus the recovery field `chan_cfg[9:8]` clocks (4, 3, 2 or 1). The gap is counted from the clock after the strobe falls to the clock before `ready` rises.
- R4: The master uses flag nibble `chan_cfg[3:0]` and the slave uses `chan_cfg[7:4]`, as picked by `drv_sel` (0 = master). Flag bit 0 enables fast timing. When it is clear, a compatible timing of a 6-clock strobe and 4 recovery clocks applies. Flag bit 2 (prefetch) has no effect on timing.
- R5: When flag bit 3 (fast timing for DMA only) is set for the selected drive, the cycle uses the compatible timing even if flag bit 0 is set.
- R6: When `chan_cfg[14]` is set and the slave is selected, sample and recovery come from `slave_cfg`. For channel 0 these are recovery in bits 1:0 and sample in bits 3:2. For channel 1 they are recovery in bits 5:4 and sample in bits 7:6. Otherwise the slave shares the fields of `chan_cfg`.
- R7: When flag bit 1 is set for the selected drive, the strobe is held past its count for as long as `iordy` is low. When flag bit 1 is clear, `iordy` has no effect.
- R8: While `chan_cfg[15]` is clear, requests are ignored: `strobe` stays low and `ready` is low.
- R9: Strobe and recovery lengths are captured when the request is accepted. Changes to `chan_cfg` or `slave_cfg` during the cycle have no effect on it.
- R10: `cyc_done` pulses once, in the last recovery clock. `ready` is never high together with `strobe`, and `ready` returns on the clock after `cyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_cfg | input | 16 | Channel timing word |
| slave_cfg | input | 8 | Independent slave sample/recovery fields for both channels |
| req | input | 1 | Cycle request, accepted when `ready` is high |
| drv_sel | input | 1 | Drive select: 0 master, 1 slave |
| iordy | input | 1 | Drive ready; low stretches the strobe when enabled |
| ready | output | 1 | Channel enabled and idle |
| strobe | output | 1 | Read/write strobe |
| cyc_done | output | 1 | Last clock of the recovery gap |

## Verification
The bound checker follows every cycle. It checks that a strobe only starts from an enabled request, that the strobe length equals the count captured at acceptance (or exceeds it only when IORDY stretching was captured), and that the recovery gap matches its captured count. It also checks that ready and strobe never overlap and that the strobe cannot restart right after `cyc_done`. Whether the captured counts are the right ones is shown only by the bench's sweeps, which compute them from the configuration word. These sweeps cover the field decode, drive and flag selection, the slave-independence path, the IORDY stretch lengths, the disabled channel and configuration changes during a cycle.

// File: rtl/ide_pio_strobe_pkg.sv
`timescale 1ns/1ps
package ide_pio_strobe_pkg;

  // Bit positions of the channel timing word that decode depends on
  localparam int CFG_CHAN_EN   = 15;
  localparam int CFG_SLV_INDEP = 14;
  localparam int CFG_SMP_LO    = 12;
  localparam int CFG_REC_LO    = 8;
  localparam int CFG_SLV_NIB   = 4;

  // Flag nibble bit positions
  localparam int FLG_FAST     = 0;
  localparam int FLG_IORDY    = 1;
  localparam int FLG_PREFETCH = 2;
  localparam int FLG_DMA_ONLY = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACT  = 2'd1,
    SEQ_REC  = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic dma_only;
    logic prefetch;
    logic use_iordy;
    logic fast;
  } drv_flags_t;

  // Subtractive encodings of the 2-bit timing fields
  function automatic int strobe_clocks(input logic [1:0] fld);
    return 5 - int'(fld);
  endfunction

  function automatic int recovery_clocks(input logic [1:0] fld);
    return 4 - int'(fld);
  endfunction

endpackage

// File: rtl/ide_pio_decode.sv
`timescale 1ns/1ps
module ide_pio_decode
  import ide_pio_strobe_pkg::*;
#(
  parameter int CHANNEL_ID    = 0,
  parameter int COMPAT_ACTIVE = 6,
  parameter int COMPAT_RECOV  = 4,
  parameter int CNT_W         = 3
) (
  input  logic [15:0]      chan_cfg,
  input  logic [7:0]       slave_cfg,
  input  logic             drv_sel,
  output logic [CNT_W-1:0] act_cnt,
  output logic [CNT_W-1:0] rec_cnt,
  output logic             use_iordy,
  output logic             fast_sel
);

  localparam int SIDE_LO = (CHANNEL_ID == 0) ? 0 : 4;

  drv_flags_t flags;
  logic [1:0] side_smp;
  logic [1:0] side_rec;
  logic [1:0] smp_fld;
  logic [1:0] rec_fld;
  logic       indep;

  generate
    if (CHANNEL_ID == 0) begin : g_primary
      assign side_rec = slave_cfg[1:0];
      assign side_smp = slave_cfg[3:2];
    end else begin : g_secondary
      assign side_rec = slave_cfg[5:4];
      assign side_smp = slave_cfg[7:6];
    end
  endgenerate

  always_comb begin
    flags = drv_sel ? drv_flags_t'(chan_cfg[CFG_SLV_NIB +: 4])
                    : drv_flags_t'(chan_cfg[3:0]);
    indep = drv_sel & chan_cfg[CFG_SLV_INDEP];
    smp_fld = indep ? side_smp : chan_cfg[CFG_SMP_LO +: 2];
    rec_fld = indep ? side_rec : chan_cfg[CFG_REC_LO +: 2];
    fast_sel = flags.fast & ~flags.dma_only;
    use_iordy = flags.use_iordy;
    if (fast_sel) begin
      act_cnt = CNT_W'(strobe_clocks(smp_fld));
      rec_cnt = CNT_W'(recovery_clocks(rec_fld));
    end else begin
      act_cnt = CNT_W'(COMPAT_ACTIVE);
      rec_cnt = CNT_W'(COMPAT_RECOV);
    end
  end

  logic unused_sig;
  assign unused_sig = ^{SIDE_LO[0], flags.prefetch};

endmodule

// File: rtl/ide_pio_seq.sv
`timescale 1ns/1ps
module ide_pio_seq
  import ide_pio_strobe_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] act_cnt,
  input  logic [CNT_W-1:0] rec_cnt,
  input  logic             use_iordy,
  input  logic             iordy,
  output logic             strobe,
  output logic             idle,
  output logic             last_rec,
  output logic             stretch
);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rec_hold;
  logic             iordy_en;

  assign stretch  = (state == SEQ_ACT) && (cnt == '0) && iordy_en && !iordy;
  assign strobe   = (state == SEQ_ACT);
  assign idle     = (state == SEQ_IDLE);
  assign last_rec = (state == SEQ_REC) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      cnt      <= '0;
      rec_hold <= '0;
      iordy_en <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start) begin
            state    <= SEQ_ACT;
            cnt      <= act_cnt - CNT_W'(1);
            rec_hold <= rec_cnt;
            iordy_en <= use_iordy;
          end
        end
        SEQ_ACT: begin
          if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (!stretch) begin
            state <= SEQ_REC;
            cnt   <= rec_hold - CNT_W'(1);
          end
        end
        SEQ_REC: begin
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
          else state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ide_pio_strobe_gen.sv
`timescale 1ns/1ps
module ide_pio_strobe_gen
  import ide_pio_strobe_pkg::*;
#(
  parameter int CHANNEL_ID    = 0,
  parameter int COMPAT_ACTIVE = 6,
  parameter int COMPAT_RECOV  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] chan_cfg,
  input  logic [7:0]  slave_cfg,
  input  logic        req,
  input  logic        drv_sel,
  input  logic        iordy,
  output logic        ready,
  output logic        strobe,
  output logic        cyc_done
);

  localparam int MAX_CLK = (COMPAT_ACTIVE > 5) ? COMPAT_ACTIVE : 5;
  localparam int MAX_ALL = (COMPAT_RECOV > MAX_CLK) ? COMPAT_RECOV : MAX_CLK;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);

  logic [CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] rec_cnt;
  logic             use_iordy;
  logic             fast_sel;
  logic             idle;
  logic             accept;
  logic             stretch;
  logic             chan_en;

  assign chan_en = chan_cfg[CFG_CHAN_EN];
  assign ready   = idle & chan_en;
  assign accept  = req & ready;

  ide_pio_decode #(
    .CHANNEL_ID   (CHANNEL_ID),
    .COMPAT_ACTIVE(COMPAT_ACTIVE),
    .COMPAT_RECOV (COMPAT_RECOV),
    .CNT_W        (CNT_W)
  ) u_decode (
    .chan_cfg (chan_cfg),
    .slave_cfg(slave_cfg),
    .drv_sel  (drv_sel),
    .act_cnt  (act_cnt),
    .rec_cnt  (rec_cnt),
    .use_iordy(use_iordy),
    .fast_sel (fast_sel)
  );

  ide_pio_seq #(
    .CNT_W(CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .act_cnt  (act_cnt),
    .rec_cnt  (rec_cnt),
    .use_iordy(use_iordy),
    .iordy    (iordy),
    .strobe   (strobe),
    .idle     (idle),
    .last_rec (cyc_done),
    .stretch  (stretch)
  );

endmodule

// File: rtl/ide_pio_strobe_chk.sv
`timescale 1ns/1ps
module ide_pio_strobe_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_en,
  input logic             req,
  input logic             accept,
  input logic             idle,
  input logic             ready,
  input logic             strobe,
  input logic             cyc_done,
  input logic [CNT_W-1:0] act_cnt,
  input logic [CNT_W-1:0] rec_cnt,
  input logic             use_iordy
);

  logic [7:0] exp_act;
  logic [7:0] exp_rec;
  logic       iordy_cap;
  logic [7:0] act_len;
  logic [7:0] rec_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_act   <= '0;
      exp_rec   <= '0;
      iordy_cap <= 1'b0;
      act_len   <= '0;
      rec_len   <= '0;
    end else begin
      if (accept) begin
        exp_act   <= 8'(act_cnt);
        exp_rec   <= 8'(rec_cnt);
        iordy_cap <= use_iordy;
        act_len   <= '0;
      end else if (strobe && act_len != 8'hFF) begin
        act_len <= act_len + 8'd1;
      end
      if (idle) rec_len <= '0;
      else if (!strobe && rec_len != 8'hFF) rec_len <= rec_len + 8'd1;
    end
  end

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> $past(chan_en && req)) else $error("strobe began without enabled request"); // R8

  AST_STROBE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(strobe) && !iordy_cap) |-> (act_len == exp_act)) else $error("strobe length differs from captured count"); // R9

  AST_STROBE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> (act_len >= exp_act)) else $error("strobe shorter than captured count"); // R7

  AST_RECOVERY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (rec_len + 8'd1 == exp_rec)) else $error("recovery gap length wrong"); // R3

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && strobe)) else $error("ready with strobe"); // R10

  AST_DONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> (!strobe && !cyc_done)) else $error("strobe right after done"); // R10

endmodule

bind ide_pio_strobe_gen ide_pio_strobe_chk #(
  .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .req      (req),
  .accept   (accept),
  .idle     (idle),
  .ready    (ready),
  .strobe   (strobe),
  .cyc_done (cyc_done),
  .act_cnt  (act_cnt),
  .rec_cnt  (rec_cnt),
  .use_iordy(use_iordy)
);

// File: tb/ide_pio_strobe_gen_bench.sv
`timescale 1ns/1ps
module ide_pio_strobe_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chan_cfg = 16'h8000;
  logic [7:0]  slave_cfg = 8'h00;
  logic        req = 1'b0;
  logic        drv_sel = 1'b0;
  logic        iordy = 1'b1;
  logic        ready;
  logic        strobe;
  logic        cyc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ide_pio_strobe_gen u_ide_pio_strobe_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_cfg (chan_cfg),
    .slave_cfg(slave_cfg),
    .req      (req),
    .drv_sel  (drv_sel),
    .iordy    (iordy),
    .ready    (ready),
    .strobe   (strobe),
    .cyc_done (cyc_done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected values derived from the requirement text
  function automatic bit is_fast(input logic [15:0] c, input logic d);
    logic [3:0] f;
    f = d ? c[7:4] : c[3:0];
    return f[0] && !f[3];
  endfunction

  function automatic int want_act(input logic [15:0] c, input logic [7:0] s, input logic d);
    int fld;
    if (!is_fast(c, d)) return 6;
    fld = (d && c[14]) ? int'(s[3:2]) : int'(c[13:12]);
    return 5 - fld;
  endfunction

  function automatic int want_rec(input logic [15:0] c, input logic [7:0] s, input logic d);
    int fld;
    if (!is_fast(c, d)) return 4;
    fld = (d && c[14]) ? int'(s[1:0]) : int'(c[9:8]);
    return 4 - fld;
  endfunction

  // One bus cycle; iordy held low for the first low_len strobe clocks (255 = whole strobe)
  task automatic run_txn(input logic [15:0] c, input logic [7:0] s, input logic d,
                         input int low_len, input bit chg, input logic [15:0] c2,
                         output int act, output int rec, output int dn);
    int guard;
    act = 0; rec = 0; dn = 0; guard = 0;
    chan_cfg = c; slave_cfg = s; drv_sel = d;
    iordy = (low_len == 0);
    while (!ready && guard < 50) begin @(negedge clk); guard++; end
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (strobe && guard < 200) begin
      act++;
      if (act == 1 && chg) begin chan_cfg = c2; slave_cfg = ~s; end
      if (act == low_len) iordy = 1'b1;
      @(negedge clk); guard++;
    end
    iordy = 1'b1;
    while (!ready && guard < 300) begin
      rec++;
      if (cyc_done) dn++;
      @(negedge clk); guard++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, r, n, bad;
    logic [15:0] c;
    logic [7:0]  s;
    logic [3:0]  sel_f, oth_f;

    // R1: reset state
    @(negedge clk);
    check(strobe == 1'b0 && cyc_done == 1'b0, "R1 reset strobe/done", int'(strobe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);

    // R2 R3 R4 R5 R6: sweep drive, slave independence, fields and flag modes
    for (int d = 0; d < 2; d++)
      for (int ind = 0; ind < 2; ind++)
        for (int sf = 0; sf < 4; sf++)
          for (int rf = 0; rf < 4; rf++)
            for (int m = 0; m < 4; m++) begin
              case (m)
                0: sel_f = 4'b0000;
                1: sel_f = 4'b0001;
                2: sel_f = 4'b1001;
                default: sel_f = 4'b0101;
              endcase
              oth_f = (m == 0) ? 4'b0001 : 4'b1000;
              c = 16'h8000;
              c[14] = ind[0];
              c[13:12] = sf[1:0];
              c[9:8] = rf[1:0];
              if (d == 1) begin c[7:4] = sel_f; c[3:0] = oth_f; end
              else begin c[3:0] = sel_f; c[7:4] = oth_f; end
              s = {sf[1:0] ^ 2'b01, rf[1:0] ^ 2'b10, ~sf[1:0], rf[1:0] + 2'd1};
              run_txn(c, s, d[0], 255, 1'b0, 16'h0, a, r, n);
              check(a == want_act(c, s, d[0]), "R2/R4/R5/R6 strobe length", a, want_act(c, s, d[0]));
              check(r == want_rec(c, s, d[0]), "R3/R4/R5/R6 recovery length", r, want_rec(c, s, d[0]));
              check(n == 1, "R10 one done pulse", n, 1);
            end

    // R7: IORDY stretch, master fast with iordy use, sample field 0 -> 5 clocks
    for (int L = 1; L < 10; L++) begin
      c = 16'h8003;
      run_txn(c, 8'h00, 1'b0, L, 1'b0, 16'h0, a, r, n);
      check(a == ((L > 5) ? L : 5), "R7 stretched strobe", a, (L > 5) ? L : 5);
      check(r == 4, "R7 recovery after stretch", r, 4);
    end
    // R7: iordy low but use flag clear -> ignored
    run_txn(16'h8001, 8'h00, 1'b0, 255, 1'b0, 16'h0, a, r, n);
    check(a == 5, "R7 iordy ignored when flag clear", a, 5);
    // R7: slave uses its own nibble's iordy bit
    run_txn(16'h8023, 8'h00, 1'b1, 8, 1'b0, 16'h0, a, r, n);
    check(a == 8, "R7 slave iordy bit", a, 8);

    // R9: config change during a cycle has no effect
    run_txn(16'h8001, 8'h00, 1'b0, 0, 1'b1, 16'hB300, a, r, n);
    check(a == 5, "R9 strobe held through cfg change", a, 5);
    check(r == 4, "R9 recovery held through cfg change", r, 4);
    run_txn(16'hC010, 8'h0F, 1'b1, 0, 1'b1, 16'hC000, a, r, n);
    check(a == 2 && r == 1, "R9 slave side word held", a * 10 + r, 21);

    // R8: channel disabled ignores requests
    chan_cfg = 16'h0001; drv_sel = 1'b0; req = 1'b1;
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (strobe || ready) bad++;
    end
    req = 1'b0;
    check(bad == 0, "R8 disabled channel idle", bad, 0);
    run_txn(16'h8001, 8'h00, 1'b0, 0, 1'b0, 16'h0, a, r, n);
    check(a == 5, "R8 works after re-enable", a, 5);

    // R10: ready returns the clock after done, and no overlap with strobe
    chan_cfg = 16'h8301; req = 1'b1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ready && strobe) bad++;
      if (cyc_done) begin
        @(negedge clk);
        if (!ready) bad++;
      end
    end
    req = 1'b0;
    check(bad == 0, "R10 ready/strobe/done ordering", bad, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule